// File: doc/BRIEF.md
# Read Turnaround Gap Inserter

This block sits beside the timing engine of a shared external peripheral bus. Some peripherals need extra time after a read to turn off their data drivers. The block adds that time as idle cycles, and it can give each chip select a different amount. A 32-bit configuration word holds one small count per chip select. There are eight chip selects, and each count can be set from 0 to 3 cycles. The word is written and read back through a plain register port.

The block samples three inputs on each clock: the end-of-access strobe, the read/write flag and the number of the chip select that was just used. When a read finishes, it takes the count for that chip select and raises `gap_busy` for exactly that many cycles. While `gap_busy` is high, the bus engine must not start any new access, to any chip select. The idle cycles are added on top of whatever hold or turnaround cycles the engine already applies, and they replace none of them. The count applies in the same way to single-beat and burst reads. Writes never get idle cycles.

Top module: `rd_turnaround_gap`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x33333333 (every count is 3) and `gap_busy` is low.
- R2: A cycle with `cfg_wr_en` high loads the count of chip select k from `cfg_wdata[4k+1:4k]`. Bits `[4k+3:4k+2]` are reserved: they always read 0 and ignore writes. The new value is visible on `cfg_rdata` from the next cycle.
- R3: If `acc_end` and `acc_is_read` are high in cycle t while `gap_busy` is low, and the count n of chip select `acc_cs` is 1 to 3, then `gap_busy` is high in cycles t+1 to t+n and low in cycle t+n+1.
- R4: A read end on a chip select whose count is 0 leaves `gap_busy` low, so a new access can start in cycle t+1.
- R5: An access end with `acc_is_read` low (a write) never raises `gap_busy`.
- R6: The count is the one held in the register at the read end. A register write in the same cycle as the read end, or during the idle period, does not change the length of that idle period.
- R7: An `acc_end` that arrives while `gap_busy` is high is ignored, so the idle period is never longer than 3 cycles.
- R8: Each chip select uses its own count. With distinct counts programmed, read ends on each chip select in turn give busy windows of those distinct lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data for the configuration word |
| cfg_rdata | output | 32 | Current configuration word (reserved bits read 0) |
| acc_end | input | 1 | Strobe marking the last cycle of a bus access |
| acc_is_read | input | 1 | High when the access that is ending is a read |
| acc_cs | input | 3 | Chip select of the access that is ending |
| gap_busy | output | 1 | High during inserted idle cycles; blocks the start of any access |

## Verification
Two functions can fall in the same cycle: a configuration write, and a read end that samples the count being rewritten. The bench drives both together. It changes chip select 1's count from 0 to 3 in the same cycle that chip select 1 reports a read end. It also rewrites a count while an idle period is still running. In both cases the busy window must be as long as the count held before the write, and the new value must show on the read-back port afterwards. A cycle-by-cycle behavioural model judges every clock, and dedicated window counts confirm the exact lengths.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
    localparam int DEF_NUM_CS  = 8;
    localparam int DEF_CNT_W   = 2;
    localparam int DEF_GRP_W   = 4;
    localparam int DEF_RST_CNT = 3;

    // lowest bit of the count field that belongs to chip select g
    function automatic int unsigned grp_lo(input int unsigned g, input int unsigned grp_w);
        return g * grp_w;
    endfunction
endpackage

// File: rtl/rtg_cfg_reg.sv
`timescale 1ns/1ps
module rtg_cfg_reg #(
    parameter int NUM_CS  = rtg_pkg::DEF_NUM_CS,
    parameter int CNT_W   = rtg_pkg::DEF_CNT_W,
    parameter int GRP_W   = rtg_pkg::DEF_GRP_W,
    parameter int RST_CNT = rtg_pkg::DEF_RST_CNT,
    localparam int CFG_W  = NUM_CS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);
    localparam int RSV_W = GRP_W - CNT_W;

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } reg_state_t;

    reg_state_t state_d, state_q;
    logic [CFG_W-1:0] wr_masked;
    logic [CFG_W-1:0] rst_word;

    // keep only the count bits of each group; reserved bits stay zero
    for (genvar g = 0; g < NUM_CS; g++) begin : g_grp
        localparam int LO = int'(rtg_pkg::grp_lo(g, GRP_W));
        assign wr_masked[LO +: CNT_W]        = wdata[LO +: CNT_W];
        assign wr_masked[LO + CNT_W +: RSV_W] = '0;
        assign rst_word[LO +: CNT_W]         = CNT_W'(RST_CNT);
        assign rst_word[LO + CNT_W +: RSV_W]  = '0;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.word = wr_masked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.word <= rst_word;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg = state_q.word;
endmodule

// File: rtl/rtg_field_sel.sv
`timescale 1ns/1ps
module rtg_field_sel #(
    parameter int NUM_CS = rtg_pkg::DEF_NUM_CS,
    parameter int CNT_W  = rtg_pkg::DEF_CNT_W,
    parameter int GRP_W  = rtg_pkg::DEF_GRP_W,
    localparam int CFG_W = NUM_CS * GRP_W,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic [CFG_W-1:0] cfg,
    input  logic [CS_W-1:0]  cs,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] fields [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign fields[g] = cfg[int'(rtg_pkg::grp_lo(g, GRP_W)) +: CNT_W];
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs == CS_W'(i)) begin
                cnt = fields[i];
            end
        end
    end
endmodule

// File: rtl/rtg_gap_timer.sv
`timescale 1ns/1ps
module rtg_gap_timer #(
    parameter int CNT_W = rtg_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_evt,
    input  logic             is_read,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    typedef struct packed {
        logic [CNT_W-1:0] left;
    } tmr_state_t;

    tmr_state_t state_d, state_q;
    logic       running;

    assign running = (state_q.left != '0);

    always_comb begin
        state_d = state_q;
        if (running) begin
            // an end strobe during the gap is ignored
            state_d.left = state_q.left - CNT_W'(1);
        end else if (end_evt && is_read) begin
            state_d.left = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.left <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = running;
endmodule

// File: rtl/rd_turnaround_gap.sv
`timescale 1ns/1ps
module rd_turnaround_gap #(
    parameter int NUM_CS  = rtg_pkg::DEF_NUM_CS,
    parameter int CNT_W   = rtg_pkg::DEF_CNT_W,
    parameter int GRP_W   = rtg_pkg::DEF_GRP_W,
    parameter int RST_CNT = rtg_pkg::DEF_RST_CNT,
    localparam int CFG_W  = NUM_CS * GRP_W,
    localparam int CS_W   = $clog2(NUM_CS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             acc_end,
    input  logic             acc_is_read,
    input  logic [CS_W-1:0]  acc_cs,
    output logic             gap_busy
);
    logic [CFG_W-1:0] cfg_word;
    logic [CNT_W-1:0] sel_cnt;

    rtg_cfg_reg #(
        .NUM_CS (NUM_CS),
        .CNT_W  (CNT_W),
        .GRP_W  (GRP_W),
        .RST_CNT(RST_CNT)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(cfg_wr_en),
        .wdata(cfg_wdata),
        .cfg  (cfg_word)
    );

    // the timer loads from the value held before this cycle's write
    rtg_field_sel #(
        .NUM_CS(NUM_CS),
        .CNT_W (CNT_W),
        .GRP_W (GRP_W)
    ) u_sel (
        .cfg(cfg_word),
        .cs (acc_cs),
        .cnt(sel_cnt)
    );

    rtg_gap_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .end_evt (acc_end),
        .is_read (acc_is_read),
        .load_val(sel_cnt),
        .busy    (gap_busy)
    );

    assign cfg_rdata = cfg_word;
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
    parameter int NUM_CS = rtg_pkg::DEF_NUM_CS,
    parameter int CNT_W  = rtg_pkg::DEF_CNT_W,
    parameter int GRP_W  = rtg_pkg::DEF_GRP_W,
    localparam int CFG_W = NUM_CS * GRP_W,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             acc_end,
    input logic             acc_is_read,
    input logic [CS_W-1:0]  acc_cs,
    input logic             gap_busy
);
    localparam int MAX_RUN = (1 << CNT_W) - 1;

    logic [CFG_W-1:0] cnt_mask;
    for (genvar g = 0; g < NUM_CS; g++) begin : g_mask
        assign cnt_mask[g*GRP_W +: GRP_W] = GRP_W'((1 << CNT_W) - 1);
    end

    logic [CNT_W-1:0] cur_cnt;
    assign cur_cnt = cfg_rdata[acc_cs*GRP_W +: CNT_W];

    int run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else if (gap_busy) run_len <= run_len + 1;
        else run_len <= 0;
    end

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~cnt_mask) == '0);

    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata == ($past(cfg_wdata) & cnt_mask));

    p_gap_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && acc_is_read && !gap_busy && cur_cnt != '0) |=> gap_busy);

    p_zero_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && acc_is_read && !gap_busy && cur_cnt == '0) |=> !gap_busy);

    p_write_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && !acc_is_read && !gap_busy) |=> !gap_busy);

    p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= MAX_RUN);
endmodule

bind rd_turnaround_gap rtg_checker #(
    .NUM_CS(NUM_CS),
    .CNT_W (CNT_W),
    .GRP_W (GRP_W)
) u_rtg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .acc_end    (acc_end),
    .acc_is_read(acc_is_read),
    .acc_cs     (acc_cs),
    .gap_busy   (gap_busy)
);

// File: tb/tb_rd_turnaround_gap.sv
`timescale 1ns/1ps
module tb_rd_turnaround_gap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_end = 1'b0;
    logic        acc_is_read = 1'b0;
    logic [2:0]  acc_cs = '0;
    logic        gap_busy;

    always #2 clk = ~clk;

    rd_turnaround_gap dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_end(acc_end), .acc_is_read(acc_is_read),
        .acc_cs(acc_cs), .gap_busy(gap_busy)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference model
    logic [31:0] m_cfg = 32'h33333333;
    int          m_left = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg  = 32'h33333333;
            m_left = 0;
        end else begin
            if (m_left > 0) m_left = m_left - 1;
            else if (acc_end && acc_is_read) m_left = int'((m_cfg >> (int'(acc_cs) * 4)) & 32'h3);
            if (cfg_wr_en) m_cfg = cfg_wdata & 32'h33333333;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int busy_seen = 0;
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "busy vs model", int'(gap_busy), int'(m_left != 0));
            check(cur_req, "rdata vs model", int'(cfg_rdata), int'(m_cfg));
            if (gap_busy) busy_seen++;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", wd);
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        acc_end = 0; acc_is_read = 0; cfg_wr_en = 0;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        step();
        cfg_wr_en = 1; cfg_wdata = v;
        step();
        idle_inputs();
    endtask

    // one access end, then count busy cycles over a fixed window
    task automatic gap_len(input string req, input logic rd, input int cs, input int exp);
        step();
        busy_seen = 0;
        acc_end = 1; acc_is_read = rd; acc_cs = 3'(cs);
        step();
        idle_inputs();
        repeat (5) step();
        check(req, $sformatf("gap length cs%0d", cs), busy_seen, exp);
    endtask

    initial begin
        idle_inputs();
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset value and idle output
        check("R1", "reset rdata", int'(cfg_rdata), int'(32'h33333333));
        check("R1", "reset busy", int'(gap_busy), 0);

        cur_req = "R3";
        gap_len("R3", 1'b1, 5, 3);

        cur_req = "R5";
        gap_len("R5", 1'b0, 5, 0);

        cur_req = "R2";
        cfg_write(32'h12345678);
        check("R2", "masked write", int'(cfg_rdata), int'(32'h12301230));

        // R8: counts per cs are 0,3,2,1,0,3,2,1; zeros are R4
        cur_req = "R8";
        for (int cs = 0; cs < 8; cs++) begin
            int e;
            e = (cs % 4 == 0) ? 0 : 4 - (cs % 4);
            gap_len((e == 0) ? "R4" : "R8", 1'b1, cs, e);
        end

        // R6: write during idle period does not shorten it
        cur_req = "R6";
        step();
        busy_seen = 0;
        acc_end = 1; acc_is_read = 1; acc_cs = 3'd1;
        step();
        idle_inputs();
        cfg_wr_en = 1; cfg_wdata = 32'h0;
        step();
        idle_inputs();
        repeat (5) step();
        check("R6", "gap after mid-gap write", busy_seen, 3);
        check("R6", "rdata after mid-gap write", int'(cfg_rdata), 0);

        // R6: write in the same cycle as the read end uses old count (0)
        step();
        busy_seen = 0;
        acc_end = 1; acc_is_read = 1; acc_cs = 3'd1;
        cfg_wr_en = 1; cfg_wdata = 32'h00000030;
        step();
        idle_inputs();
        repeat (5) step();
        check("R6", "same-cycle write gap", busy_seen, 0);
        check("R6", "same-cycle write rdata", int'(cfg_rdata), int'(32'h30));
        gap_len("R6", 1'b1, 1, 3);

        // R7: an end strobe during the gap is ignored
        cur_req = "R7";
        step();
        busy_seen = 0;
        acc_end = 1; acc_is_read = 1; acc_cs = 3'd1;
        step();
        step();
        idle_inputs();
        repeat (5) step();
        check("R7", "gap with extra end strobe", busy_seen, 3);

        // R4: zero count lets back-to-back read ends pass
        cur_req = "R4";
        step();
        busy_seen = 0;
        acc_end = 1; acc_is_read = 1; acc_cs = 3'd0;
        repeat (3) step();
        idle_inputs();
        repeat (3) step();
        check("R4", "back-to-back zero-count reads", busy_seen, 0);

        finish_run();
    end
endmodule